// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block paces refresh work for an SDRAM controller. An interval counter runs on the memory clock and marks one refresh period each time it reaches the programmed length. Every marked period is held in a small pending counter until the sequencer can service it. A serviced period is a refresh round. It consists of an optional precharge-all request, when banks are still open, then a wait for the precharge-to-refresh spacing, then a programmable number of refresh commands issued back to back.

Each refresh command is followed by a recovery window, during which the controller must not open a row. The scheduler raises an activate-block output for the whole round, from the cycle it leaves idle until the recovery window of its last refresh command has passed.

Requests are level signals that stay high until the controller acknowledges them with a one-cycle `cmd_ack` pulse. That pulse marks the clock edge on which the command goes out.

Top module: `rfsh_sched`

## Requirements
- R1: With `intv_cycles` = N > 0, a refresh period is marked every N clock cycles, at edges N, 2N, 3N, ... after reset release. A round leaves idle at the edge after the mark, and `act_block` is high from that cycle on.
- R2: `intv_cycles` = 0 stops the marking of new periods. With nothing pending, no request is ever raised.
- R3: If `banks_idle` is 0 when a round starts, `prea_req` is raised in the first round cycle. No `refresh_req` is raised before that precharge is acknowledged, and the two requests are never high together.
- R4: The first `refresh_req` of a round rises max(`t_rp_cycles`,1) cycles after the precharge acknowledge edge. If the banks were already idle, it rises that many cycles after the round starts.
- R5: A round issues `refs_per_cycle` refresh commands, and a value of 0 is treated as 1. After the first, each command is requested max(`t_rfc_cycles`,1) cycles after the previous one is acknowledged.
- R6: After each refresh acknowledge, `act_block` stays high for max(`t_rfc_cycles`,1) cycles. After the last command of a round, `act_block` falls exactly at the end of that window.
- R7: `prea_req` and `refresh_req` each stay high until `cmd_ack` is seen.
- R8: Periods keep being marked while a round is in progress or waiting. Up to 2^PEND_W-1 marked periods are kept, and each one is later served by a round of its own, with rounds starting one cycle after the previous round ends.
- R9: While reset is asserted, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intv_cycles | input | INTV_W | Refresh period length in cycles, 0 = off |
| refs_per_cycle | input | CNT_W | Refresh commands per round, 0 read as 1 |
| t_rp_cycles | input | DLY_W | Precharge-to-refresh spacing |
| t_rfc_cycles | input | DLY_W | Refresh-to-activate recovery |
| banks_idle | input | 1 | All banks closed |
| cmd_ack | input | 1 | Controller issued the requested command this cycle |
| refresh_req | output | 1 | Refresh command requested |
| prea_req | output | 1 | Precharge-all requested |
| act_block | output | 1 | Activates forbidden |

## Verification
The bench builds the scheduler with a 12-bit interval, a 4-bit command count, 6-bit delays and a 3-bit pending counter. These widths let refresh periods of 20 to 100 cycles make several rounds complete within a few hundred cycles. They also let a withheld precharge acknowledge span three periods, so that two marked periods pile up in the pending counter and drain in rounds that follow one another. The delay widths cover both the zero spacings that are rounded up to one cycle and multi-cycle spacings, and the count width covers a zero command count as well as four commands in one round.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREA = 3'd1,
    ST_RPW  = 3'd2,
    ST_REF  = 3'd3,
    ST_RFC  = 3'd4
  } rfsh_st_e;
endpackage

// File: rtl/rfsh_intv_ctr.sv
module rfsh_intv_ctr #(
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INTV_W-1:0] intv,
  output logic              tick
);
  logic [INTV_W-1:0] cnt_q, cnt_d;
  logic              run;

  assign run  = (intv != '0);
  assign tick = run && (cnt_q >= intv - INTV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + INTV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pend_nz
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign pend_nz = (cnt_q != '0);
  assign cnt_en  = tick ^ take;

  always_comb begin
    cnt_d = cnt_q;
    if (tick && !take && cnt_q != PEND_MAX) cnt_d = cnt_q + PEND_W'(1);
    else if (take && !tick)                 cnt_d = cnt_q - PEND_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_nz,
  input  logic             banks_idle,
  input  logic             cmd_ack,
  input  logic [CNT_W-1:0] burst,
  input  logic [DLY_W-1:0] t_rp,
  input  logic [DLY_W-1:0] t_rfc,
  output logic             take,
  output rfsh_st_e         st
);
  rfsh_st_e         st_q, st_d;
  logic [DLY_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] burst_eff;
  logic             tmr_done;

  assign burst_eff = (burst == '0) ? CNT_W'(1) : burst;
  assign tmr_done  = (tmr_q <= DLY_W'(1));
  assign st        = st_q;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    rem_d = rem_q;
    take  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pend_nz) begin
        take  = 1'b1;
        rem_d = burst_eff;
        if (banks_idle) begin
          st_d  = ST_RPW;
          tmr_d = t_rp;
        end else begin
          st_d  = ST_PREA;
        end
      end
      ST_PREA: if (cmd_ack) begin
        st_d  = ST_RPW;
        tmr_d = t_rp;
      end
      ST_RPW: begin
        if (tmr_done) st_d  = ST_REF;
        else          tmr_d = tmr_q - DLY_W'(1);
      end
      ST_REF: if (cmd_ack) begin
        st_d  = ST_RFC;
        tmr_d = t_rfc;
        rem_d = rem_q - CNT_W'(1);
      end
      ST_RFC: begin
        if (tmr_done) st_d  = (rem_q != '0) ? ST_REF : ST_IDLE;
        else          tmr_d = tmr_q - DLY_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int INTV_W = 16,
  parameter int CNT_W  = 4,
  parameter int DLY_W  = 8,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INTV_W-1:0] intv_cycles,
  input  logic [CNT_W-1:0]  refs_per_cycle,
  input  logic [DLY_W-1:0]  t_rp_cycles,
  input  logic [DLY_W-1:0]  t_rfc_cycles,
  input  logic              banks_idle,
  input  logic              cmd_ack,
  output logic              refresh_req,
  output logic              prea_req,
  output logic              act_block
);
  logic     tick, take, pend_nz;
  rfsh_st_e st;

  rfsh_intv_ctr #(.INTV_W(INTV_W)) u_intv (
    .clk(clk), .rst_n(rst_n), .intv(intv_cycles), .tick(tick)
  );

  rfsh_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .pend_nz(pend_nz)
  );

  rfsh_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .banks_idle(banks_idle),
    .cmd_ack(cmd_ack), .burst(refs_per_cycle), .t_rp(t_rp_cycles),
    .t_rfc(t_rfc_cycles), .take(take), .st(st)
  );

  assign refresh_req = (st == ST_REF);
  assign prea_req    = (st == ST_PREA);
  assign act_block   = (st != ST_IDLE);
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ack,
  input logic refresh_req,
  input logic prea_req,
  input logic act_block
);
  // R7
  prea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prea_req && !cmd_ack |=> prea_req);

  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !cmd_ack |=> refresh_req);

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prea_req && refresh_req));

  // R4
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_req) |-> !$past(prea_req));

  // R6
  rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && cmd_ack |=> act_block && !refresh_req);

  // R6
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req || prea_req) |-> act_block);
endmodule

bind rfsh_sched rfsh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ack(cmd_ack), .refresh_req(refresh_req),
  .prea_req(prea_req), .act_block(act_block)
);

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;
  localparam int INTV_W = 12;
  localparam int CNT_W  = 4;
  localparam int DLY_W  = 6;
  localparam int PEND_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [INTV_W-1:0] intv = '0;
  logic [CNT_W-1:0]  refs = '0;
  logic [DLY_W-1:0]  t_rp = '0;
  logic [DLY_W-1:0]  t_rfc = '0;
  logic banks_idle = 1'b1;
  logic cmd_ack = 1'b0;
  logic refresh_req, prea_req, act_block;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int plag = 0, rlag = 0, wcnt = 0;
  int  q_kind[$];
  int  q_cyc[$];
  string q_tag[$];
  logic pv_ref = 1'b0, pv_pre = 1'b0, pv_blk = 1'b0;

  always #2.5 clk = ~clk;

  rfsh_sched #(.INTV_W(INTV_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .PEND_W(PEND_W)) uut (
    .clk(clk), .rst_n(rst_n), .intv_cycles(intv), .refs_per_cycle(refs),
    .t_rp_cycles(t_rp), .t_rfc_cycles(t_rfc), .banks_idle(banks_idle),
    .cmd_ack(cmd_ack), .refresh_req(refresh_req), .prea_req(prea_req),
    .act_block(act_block)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_ev(input int k, input int c, input string tag);
    q_kind.push_back(k);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  // Expected events of one round: A = block rise, P = precharge req rise,
  // R = refresh req rise, F = block fall. Returns the fall cycle.
  task automatic add_round(input int s, input bit open, input int b, input int d,
                           input int r, output int fall);
    int t;
    push_ev("A", s, "R1");
    if (open) begin
      push_ev("P", s, "R3");
      t = s + plag + 1 + d;
    end else begin
      t = s + d;
    end
    for (int i = 0; i < b; i++) begin
      push_ev("R", t, (i == 0) ? "R4" : "R5");
      t = t + rlag + 1 + r;
    end
    push_ev("F", t, "R6");
    fall = t;
  endtask

  // Monitor: compares every observed output edge against the queue.
  task automatic mon_ev(input int k);
    if (q_kind.size() == 0) begin
      chk(1'b0, "R2 unexpected event", k, 0);
    end else begin
      string tg;
      int ek, ec;
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      tg = q_tag.pop_front();
      chk(ek == k, {tg, " event kind"}, k, ek);
      chk(ec == cyc, {tg, " event cycle"}, cyc, ec);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (act_block && !pv_blk)   mon_ev("A");
      if (prea_req && !pv_pre)    mon_ev("P");
      if (refresh_req && !pv_ref) mon_ev("R");
      if (!act_block && pv_blk)   mon_ev("F");
    end
    pv_ref = refresh_req;
    pv_pre = prea_req;
    pv_blk = act_block;
  end

  // Acknowledger: answers a request after plag / rlag extra cycles (R7).
  always @(negedge clk) begin
    if (cmd_ack) begin
      cmd_ack = 1'b0;
    end else if (rst_n && (prea_req || refresh_req)) begin
      if (wcnt == (prea_req ? plag : rlag)) begin
        cmd_ack = 1'b1;
        wcnt = 0;
        if (prea_req) banks_idle = 1'b1;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic start_case(input int n, input int b, input int rp, input int rfc,
                            input bit idle, input int pl, input int rl);
    @(negedge clk);
    rst_n = 1'b0;
    intv = INTV_W'(n);
    refs = CNT_W'(b);
    t_rp = DLY_W'(rp);
    t_rfc = DLY_W'(rfc);
    banks_idle = idle;
    plag = pl;
    rlag = rl;
    q_kind.delete(); q_cyc.delete(); q_tag.delete();
    repeat (3) @(negedge clk);
    // R9: outputs low under reset
    chk({refresh_req, prea_req, act_block} == 3'b000, "R9 reset outputs",
        {refresh_req, prea_req, act_block}, 0);
    rst_n = 1'b1;
  endtask

  task automatic end_case(input int last, input string tag);
    wait_cyc(last);
    chk(q_kind.size() == 0, {tag, " all expected events seen"}, q_kind.size(), 0);
  endtask

  initial begin
    int f;
    // R1: periodic rounds, banks idle, spacing 2, recovery 3
    start_case(40, 1, 2, 3, 1'b1, 0, 0);
    for (int k = 1; k <= 3; k++) add_round(k * 40 + 1, 1'b0, 1, 2, 3, f);
    end_case(150, "R1");

    // R3 R4 R5: open banks, three commands, delayed refresh acks
    start_case(60, 3, 4, 5, 1'b0, 1, 2);
    add_round(61, 1'b1, 3, 4, 5, f);
    add_round(121, 1'b0, 3, 4, 5, f);
    end_case(f + 10, "R5");

    // R5: command count 0 acts as 1, zero delays round up to one cycle
    start_case(30, 0, 0, 0, 1'b1, 0, 0);
    add_round(31, 1'b0, 1, 1, 1, f);
    add_round(61, 1'b0, 1, 1, 1, f);
    end_case(80, "R5");

    // R6: four commands with long recovery
    start_case(100, 4, 1, 6, 1'b0, 0, 1);
    add_round(101, 1'b1, 4, 1, 6, f);
    end_case(f + 10, "R6");

    // R2: interval 0 never requests, even with banks open
    start_case(0, 2, 1, 1, 1'b0, 0, 0);
    end_case(300, "R2");
    chk(!act_block && !prea_req && !refresh_req, "R2 idle outputs", act_block, 0);

    // R8: precharge ack held across two more periods; both drain afterwards
    start_case(20, 1, 3, 2, 1'b0, 44, 0);
    add_round(21, 1'b1, 1, 3, 2, f);
    add_round(f + 1, 1'b0, 1, 3, 2, f);
    add_round(f + 1, 1'b0, 1, 3, 2, f);
    wait_cyc(62);
    chk(prea_req == 1'b1, "R7 precharge request held", prea_req, 1);
    intv = '0;
    end_case(f + 10, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule